// File: doc/BRIEF.md
# Processor Status Word and Interrupt Gate

This block keeps the status word of a small 16-bit CPU and decides, in the same cycle a request is shown to it, whether a maskable interrupt is taken. The core feeds it result information from the ALU together with per-flag write enables. It also sends full status-word writes, software-interrupt and return strobes, and writes to the two stack pointers. The block drives out the current status word, the register-bank select and the stack pointer in use.

The maskable request uses a valid/ready handshake. `irq_req` is valid and `irq_ack` is ready. The requester holds `irq_req` and `irq_lvl` steady until it sees `irq_ack` high at a clock edge. It may withdraw a request that has not been acknowledged. The acknowledge depends on the request in the same cycle, so a transfer completes on any edge where both are high. On entry and on a software interrupt, the block copies the previous status word into a one-deep save register. The return strobe loads that copy back. Vector fetch and pushing context to memory are left to the core.

Top module: `psw_core`

## Requirements
- R1: After reset the status word reads 0x0000, `bank_sel` is 0, `sp_active` is 0, and no request is acknowledged whatever its level.
- R2: `irq_ack` is 1 in a cycle exactly when `irq_req` is 1, the enable bit (bit 6) is 1, and `irq_lvl` is strictly greater than the level field (bits 15:13). Equal or lower priority is refused.
- R3: On an accepted request the old word is saved and the enable bit and stack-select bit (bit 7) are cleared. The level field takes `irq_lvl`. All other bits are kept. The new word is visible after that clock edge.
- R4: `swi_go` saves the word. When `swi_num` is below 32 it clears bit 7. When `swi_num` is 32 or above it changes nothing.
- R5: When none of `irq_ack`, `swi_go`, `rti` and `psw_wr` is active, each set bit of `alu_we` updates one flag: bit 0 sets C (bit 0) from `alu_carry`, bit 1 sets Z (bit 2) to (result==0), bit 2 sets S (bit 3) to the result's top bit, and bit 3 sets O (bit 5) from `alu_ovf`. Flags not enabled are kept.
- R6: `psw_wr` loads `psw_wdata`, with layout C0 D1 Z2 S3 B4 O5 I6 U7, reserved bits 12:8 and level bits 15:13. The reserved bits always read 0.
- R7: Events in the same cycle rank as follows: an accepted request first, then `swi_go`, then `rti`, then `psw_wr`, then ALU updates. Only the highest-ranking event takes effect.
- R8: `rti` loads the saved word into the status word.
- R9: `sp_wr` writes `sp_wdata` to the user pointer when `sp_wr_usp` is 1 and to the interrupt pointer when it is 0. `sp_active` shows the user pointer when bit 7 is 1 and the interrupt pointer when bit 7 is 0. `bank_sel` equals bit 4.
- R10: A request that is not accepted leaves the word unchanged. If it is held, it is acknowledged in the first cycle in which the gate condition of R2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_we | input | 4 | Per-flag update enables {O,S,Z,C} |
| alu_result | input | 16 | ALU result for Z and S |
| alu_carry | input | 1 | Carry, borrow or shifted-out bit |
| alu_ovf | input | 1 | Arithmetic overflow |
| psw_wr | input | 1 | Full status-word write strobe |
| psw_wdata | input | 16 | Status-word write data |
| irq_req | input | 1 | Maskable request valid |
| irq_lvl | input | 3 | Request priority |
| irq_ack | output | 1 | Request accepted (ready) |
| swi_go | input | 1 | Software interrupt strobe |
| swi_num | input | 6 | Software interrupt number |
| rti | input | 1 | Return strobe, restores saved word |
| sp_wr | input | 1 | Stack pointer write strobe |
| sp_wr_usp | input | 1 | 1 selects the user pointer for the write |
| sp_wdata | input | 16 | Stack pointer write data |
| psw_o | output | 16 | Current status word |
| bank_sel | output | 1 | Register bank select |
| sp_active | output | 16 | Stack pointer in use |

## Verification
The assertions assume that the core raises at most one of `swi_go`, `rti` and `psw_wr` in a cycle. The one exception is the ranking check, which deliberately pairs them. They also assume that `irq_lvl` is stable while `irq_req` waits. The assertions that check next-state values qualify each antecedent by the higher-ranking events, so the ranking cases stay legal. The stimulus drives every input on the falling edge and holds each request until it has been judged. It sweeps every combination of enable bit, level field and request priority, and every software-interrupt number.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W   = 16;
  localparam int BIT_C   = 0;
  localparam int BIT_D   = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_S   = 3;
  localparam int BIT_B   = 4;
  localparam int BIT_O   = 5;
  localparam int BIT_I   = 6;
  localparam int BIT_U   = 7;
  localparam int LVL_W   = 3;
  localparam int LVL_LSB = PSW_W - LVL_W;
  localparam logic [PSW_W-1:0] RSV_MASK = 16'h1F00;

  localparam int AW_C = 0;
  localparam int AW_Z = 1;
  localparam int AW_S = 2;
  localparam int AW_O = 3;

  typedef enum logic [2:0] {
    EV_NONE, EV_IRQ, EV_SWI, EV_RTI, EV_WR, EV_ALU
  } psw_event_e;

  function automatic logic [PSW_W-1:0] psw_clean(input logic [PSW_W-1:0] w);
    return w & ~RSV_MASK;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LVL_W = 3
) (
  input  logic             req,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic             ie,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             accept
);
  always_comb accept = req && ie && (req_lvl > cur_lvl);
endmodule

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SWI_W       = 6,
  parameter int SWI_U_LIMIT = 32
) (
  input  psw_event_e        ev,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic [PSW_W-1:0]  saved_psw,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic [SWI_W-1:0]  swi_num,
  input  logic [PSW_W-1:0]  wdata,
  input  logic [3:0]        alu_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  output logic [PSW_W-1:0]  nxt_psw,
  output logic              save_en
);
  logic swi_low;
  always_comb swi_low = (int'(swi_num) < SWI_U_LIMIT);

  always_comb begin
    nxt_psw = cur_psw;
    save_en = 1'b0;
    unique case (ev)
      EV_IRQ: begin
        save_en = 1'b1;
        nxt_psw[BIT_I] = 1'b0;
        nxt_psw[BIT_U] = 1'b0;
        nxt_psw[LVL_LSB +: LVL_W] = irq_lvl;
      end
      EV_SWI: begin
        save_en = 1'b1;
        if (swi_low) nxt_psw[BIT_U] = 1'b0;
      end
      EV_RTI: nxt_psw = saved_psw;
      EV_WR:  nxt_psw = psw_clean(wdata);
      EV_ALU: begin
        if (alu_we[AW_C]) nxt_psw[BIT_C] = alu_carry;
        if (alu_we[AW_Z]) nxt_psw[BIT_Z] = (alu_result == '0);
        if (alu_we[AW_S]) nxt_psw[BIT_S] = alu_result[DATA_W-1];
        if (alu_we[AW_O]) nxt_psw[BIT_O] = alu_ovf;
      end
      default: nxt_psw = cur_psw;
    endcase
    nxt_psw = psw_clean(nxt_psw);
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_usp,
  input  logic [SP_W-1:0] wr_data,
  input  logic            use_usp,
  output logic [SP_W-1:0] sp_o
);
  logic [SP_W-1:0] ptr_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (wr_en && (wr_usp == g[0])) ptr_q[g] <= wr_data;
    end
  end

  always_comb sp_o = use_usp ? ptr_q[1] : ptr_q[0];
endmodule

// File: rtl/psw_core.sv
module psw_core
  import psw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SP_W        = 16,
  parameter int SWI_W       = 6,
  parameter int SWI_U_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        alu_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              psw_wr,
  input  logic [15:0]       psw_wdata,
  input  logic              irq_req,
  input  logic [2:0]        irq_lvl,
  output logic              irq_ack,
  input  logic              swi_go,
  input  logic [SWI_W-1:0]  swi_num,
  input  logic              rti,
  input  logic              sp_wr,
  input  logic              sp_wr_usp,
  input  logic [SP_W-1:0]   sp_wdata,
  output logic [15:0]       psw_o,
  output logic              bank_sel,
  output logic [SP_W-1:0]   sp_active
);
  logic [PSW_W-1:0] psw_q, saved_q, psw_d;
  logic             save_en;
  psw_event_e       ev;

  irq_gate #(.LVL_W(LVL_W)) u_gate (
    .req     (irq_req),
    .req_lvl (irq_lvl),
    .ie      (psw_q[BIT_I]),
    .cur_lvl (psw_q[LVL_LSB +: LVL_W]),
    .accept  (irq_ack)
  );

  always_comb begin
    if (irq_ack)      ev = EV_IRQ;
    else if (swi_go)  ev = EV_SWI;
    else if (rti)     ev = EV_RTI;
    else if (psw_wr)  ev = EV_WR;
    else if (|alu_we) ev = EV_ALU;
    else              ev = EV_NONE;
  end

  psw_next #(.DATA_W(DATA_W), .SWI_W(SWI_W), .SWI_U_LIMIT(SWI_U_LIMIT)) u_next (
    .ev         (ev),
    .cur_psw    (psw_q),
    .saved_psw  (saved_q),
    .irq_lvl    (irq_lvl),
    .swi_num    (swi_num),
    .wdata      (psw_wdata),
    .alu_we     (alu_we),
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .alu_ovf    (alu_ovf),
    .nxt_psw    (psw_d),
    .save_en    (save_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q   <= '0;
      saved_q <= '0;
    end else begin
      psw_q <= psw_d;
      if (save_en) saved_q <= psw_q;
    end
  end

  sp_bank #(.SP_W(SP_W)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sp_wr),
    .wr_usp  (sp_wr_usp),
    .wr_data (sp_wdata),
    .use_usp (psw_q[BIT_U]),
    .sp_o    (sp_active)
  );

  always_comb begin
    psw_o    = psw_q;
    bank_sel = psw_q[BIT_B];
  end
endmodule

// File: rtl/psw_core_chk.sv
module psw_core_chk
  import psw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SWI_W       = 6,
  parameter int SWI_U_LIMIT = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        alu_we,
  input logic [DATA_W-1:0] alu_result,
  input logic              psw_wr,
  input logic [15:0]       psw_wdata,
  input logic              irq_req,
  input logic [2:0]        irq_lvl,
  input logic              irq_ack,
  input logic              swi_go,
  input logic [SWI_W-1:0]  swi_num,
  input logic              rti,
  input logic [15:0]       psw_o
);
  AST_ACK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_req && psw_o[BIT_I] && (irq_lvl > psw_o[LVL_LSB +: LVL_W]))); // R2
  AST_ACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!psw_o[BIT_I] && !psw_o[BIT_U] && psw_o[LVL_LSB +: LVL_W] == $past(irq_lvl))); // R3
  AST_SWI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_go && !irq_ack && int'(swi_num) < SWI_U_LIMIT) |=> !psw_o[BIT_U]); // R4
  AST_SWI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_go && !irq_ack && int'(swi_num) >= SWI_U_LIMIT) |=> psw_o == $past(psw_o)); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we[AW_Z] && !irq_ack && !swi_go && !rti && !psw_wr) |=> psw_o[BIT_Z] == ($past(alu_result) == '0)); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_o & RSV_MASK) == '0); // R6
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_wr && !irq_ack && !swi_go && !rti) |=> psw_o == ($past(psw_wdata) & ~RSV_MASK)); // R7
  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && !swi_go && !rti && !psw_wr && alu_we == '0) |=> psw_o == $past(psw_o)); // R10
endmodule

bind psw_core psw_core_chk #(.DATA_W(DATA_W), .SWI_W(SWI_W), .SWI_U_LIMIT(SWI_U_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_result(alu_result),
  .psw_wr(psw_wr), .psw_wdata(psw_wdata), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .irq_ack(irq_ack), .swi_go(swi_go), .swi_num(swi_num), .rti(rti), .psw_o(psw_o)
);

// File: tb/psw_core_tb_top.sv
module psw_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_we = '0;
  logic [15:0] alu_result = '0;
  logic        alu_carry = 1'b0, alu_ovf = 1'b0;
  logic        psw_wr = 1'b0;
  logic [15:0] psw_wdata = '0;
  logic        irq_req = 1'b0;
  logic [2:0]  irq_lvl = '0;
  logic        irq_ack;
  logic        swi_go = 1'b0;
  logic [5:0]  swi_num = '0;
  logic        rti = 1'b0;
  logic        sp_wr = 1'b0, sp_wr_usp = 1'b0;
  logic [15:0] sp_wdata = '0;
  logic [15:0] psw_o, sp_active;
  logic        bank_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psw_core dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_psw(input logic [15:0] v);
    psw_wr = 1'b1; psw_wdata = v;
    tick();
    psw_wr = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e;
    logic [15:0] res [4];
    res[0] = 16'h0000; res[1] = 16'h8000; res[2] = 16'h1234; res[3] = 16'hFFFF;
    repeat (3) @(negedge clk);
    irq_req = 1'b1; irq_lvl = 3'd7; #1;
    chk("R1 ack in reset", irq_ack, 0);
    irq_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 psw", psw_o, 0);
    chk("R1 bank", bank_sel, 0);
    chk("R1 sp", sp_active, 0);
    irq_req = 1'b1; irq_lvl = 3'd7; #1;
    chk("R1 ack after reset", irq_ack, 0);
    irq_req = 1'b0;
    tick();

    // R2 R3 R8 sweep over enable, level field and request level
    for (int i = 0; i < 2; i++)
      for (int p = 0; p < 8; p++)
        for (int l = 0; l < 8; l++) begin
          v = 16'(p << 13) | 16'(i << 6) | 16'h0095;
          wr_psw(v);
          irq_req = 1'b1; irq_lvl = 3'(l); #1;
          chk("R2 gate", irq_ack, ((i == 1) && (l > p)) ? 1 : 0);
          tick();
          irq_req = 1'b0;
          if ((i == 1) && (l > p)) begin
            e = (v & 16'h1F3F) | 16'(l << 13);
            chk("R3 entry word", psw_o, e);
            rti = 1'b1; tick(); rti = 1'b0;
            chk("R8 restore", psw_o, v);
          end else
            chk("R10 refused unchanged", psw_o, v);
        end

    // R10 held request accepted once enabled
    wr_psw(16'h4000);
    irq_req = 1'b1; irq_lvl = 3'd5;
    tick();
    chk("R10 held no ack", psw_o, 16'h4000);
    psw_wr = 1'b1; psw_wdata = 16'h4040; tick(); psw_wr = 1'b0; #1;
    chk("R10 ack when enabled", irq_ack, 1);
    tick(); irq_req = 1'b0;
    chk("R10 entry", psw_o, 16'hA000);

    // R4 software interrupt sweep
    for (int n = 0; n < 64; n++) begin
      wr_psw(16'h0090);
      swi_go = 1'b1; swi_num = 6'(n);
      tick();
      swi_go = 1'b0;
      chk("R4 swi", psw_o, (n < 32) ? 16'h0010 : 16'h0090);
      if (n == 5 || n == 40) begin
        wr_psw(16'h0001);
        rti = 1'b1; tick(); rti = 1'b0;
        chk("R8 swi restore", psw_o, 16'h0090);
      end
    end

    // R5 ALU flag updates, every mask and several results
    wr_psw(16'h0000);
    e = 16'h0000;
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++) begin
        alu_we = 4'(m); alu_result = res[k];
        alu_carry = k[0]; alu_ovf = m[0] ^ k[1];
        tick();
        if (m[0]) e[0] = alu_carry;
        if (m[1]) e[2] = (res[k] == 16'h0);
        if (m[2]) e[3] = res[k][15];
        if (m[3]) e[5] = alu_ovf;
        alu_we = '0;
        chk("R5 flags", psw_o, e);
      end

    // R6 layout and reserved bits
    wr_psw(16'hFFFF);
    chk("R6 reserved zero", psw_o, 16'hE0FF);
    chk("R9 bank one", bank_sel, 1);
    wr_psw(16'h1F00);
    chk("R6 reserved only", psw_o, 16'h0000);
    chk("R9 bank zero", bank_sel, 0);

    // R7 ranking
    wr_psw(16'h0040);
    psw_wr = 1'b1; psw_wdata = 16'h0000; irq_req = 1'b1; irq_lvl = 3'd5;
    tick(); psw_wr = 1'b0; irq_req = 1'b0;
    chk("R7 irq over write", psw_o, 16'hA000);
    wr_psw(16'h0080);
    swi_go = 1'b1; swi_num = 6'd3; psw_wr = 1'b1; psw_wdata = 16'hFFFF;
    tick(); swi_go = 1'b0; psw_wr = 1'b0;
    chk("R7 swi over write", psw_o, 16'h0000);
    rti = 1'b1; psw_wr = 1'b1; psw_wdata = 16'h0001;
    tick(); rti = 1'b0; psw_wr = 1'b0;
    chk("R7 rti over write", psw_o, 16'h0080);
    psw_wr = 1'b1; psw_wdata = 16'h0000; alu_we = 4'hF; alu_carry = 1'b1; alu_result = 16'h0;
    tick(); psw_wr = 1'b0; alu_we = '0;
    chk("R7 write over alu", psw_o, 16'h0000);

    // R9 stack pointers
    sp_wr = 1'b1; sp_wr_usp = 1'b0; sp_wdata = 16'h1111; tick();
    sp_wr_usp = 1'b1; sp_wdata = 16'h2222; tick(); sp_wr = 1'b0;
    chk("R9 isp active", sp_active, 16'h1111);
    wr_psw(16'h0080);
    chk("R9 usp active", sp_active, 16'h2222);
    swi_go = 1'b1; swi_num = 6'd0; tick(); swi_go = 1'b0;
    chk("R9 swi back to isp", sp_active, 16'h1111);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule